// File: doc/BRIEF.md
# Cascaded BCD Time-of-Day Counter

This block keeps a twelve-hour time of day in BCD. A chain of base-sixty stages (seconds, then minutes by default) feeds an hours stage. Each base-sixty stage holds a decimal units digit and a tens digit limited to 0..5. The hours stage holds a decimal units digit and a one-bit tens digit and runs 1 through 12. Every register shares one clock. A stage moves only on an edge where its enable is high, and the enable of each stage is the terminal count of the stage before it.

The count enable advances the first stage once per enabled clock. A synchronous reset puts the time at 12:00:00. The terminal counts are combinational. Each is the AND of its stage's "last value" decode and the enable coming into that stage, so a parent block can cascade further stages from them.

Top module: `clock_time_chain`

## Requirements
- R1: After a clock edge with `rst` high, every base-sixty digit reads 0, `hr_tens` reads 1 and `hr_units` reads 2 (12:00:00).
- R2: On an edge with `cnt_en` low and `rst` low, no digit changes.
- R3: A base-sixty units digit steps 0,1,...,9,0 on each edge where its stage is enabled. The tens digit of that stage steps only on edges where the units digit reads 9.
- R4: A base-sixty tens digit steps 0..5, never reads 6 or above, and returns to 0 together with its units digit when the stage moves from 59 to 00.
- R5: `ms_tc[i]` is high exactly when stage i is enabled and reads 59. Stage 0 is enabled by `cnt_en`, and stage i+1 is enabled by `ms_tc[i]`. Stage 0 (bits [3:0] of each digit bus) is seconds and stage 1 (bits [7:4]) is minutes.
- R6: The hours move from 09 to 10 on an enabled edge. The units digit goes to 0 and `hr_tens` goes to 1.
- R7: Enabled hours advance by one from 01 up to 12. From 12 the next enabled advance gives 01, with `hr_units`=1 and `hr_tens`=0.
- R8: `hr_tc` is high exactly when the hours stage is enabled and the hours read 12.
- R9: `rst` takes priority over `cnt_en` on the same edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock shared by all stages |
| rst | input | 1 | Synchronous reset to 12:00:00 |
| cnt_en | input | 1 | Advance enable for the first stage |
| ms_units | output | N_SEXA*4 | BCD units digits, stage 0 in the low nibble |
| ms_tens | output | N_SEXA*4 | BCD tens digits (0..5), stage 0 in the low nibble |
| ms_tc | output | N_SEXA | Terminal count of each base-sixty stage |
| hr_units | output | 4 | Hours units digit, BCD |
| hr_tens | output | 1 | Hours tens digit |
| hr_tc | output | 1 | Terminal count of the hours stage |

## Verification
The bench compares every cycle against its own time model over more than thirteen hours of counting, with pauses and alternating enables mixed in. This covers the 59 to 00 rollover, where a tens digit that shows 6 or a units digit that passes 9 would appear at once. It also covers the 09 to 10 and 12 to 01 hour changes, where a design that wraps to 00 or never sets the tens bit would be caught. Directed tests hold the time at 12:59:59 with the enable low and check that no terminal count leaks through. They also pulse reset while the enable is high, which catches a design that lets the count win over reset.

// File: rtl/clk_time_pkg.sv
package clk_time_pkg;
   localparam int unsigned BCD_W      = 4;
   localparam int unsigned UNITS_LAST = 9;
   localparam int unsigned TENS_LAST  = 5;
   localparam int unsigned HOUR_FIRST = 1;
   localparam int unsigned HOUR_LAST  = 12;

   typedef logic [BCD_W-1:0] bcd_t;
endpackage

// File: rtl/ct_digit.sv
module ct_digit #(
   parameter int unsigned W       = 4,
   parameter int unsigned LAST    = 9,
   parameter int unsigned RST_VAL = 0
) (
   input  logic         clk,
   input  logic         rst,
   input  logic         en,
   output logic [W-1:0] q,
   output logic         at_last,
   output logic         tc
);
   localparam logic [W-1:0] LAST_V = W'(LAST);
   localparam logic [W-1:0] RST_V  = W'(RST_VAL);

   initial begin
      assert (LAST < (2 ** W)) else $error("ct_digit: LAST does not fit in W");
      assert (RST_VAL <= LAST) else $error("ct_digit: RST_VAL above LAST");
   end

   assign at_last = (q == LAST_V);
   assign tc      = en & at_last;

   generate
      if (LAST == (2 ** W) - 1) begin : g_full
         always_ff @(posedge clk) begin
            if (rst)     q <= RST_V;
            else if (en) q <= q + 1'b1;
         end
      end else begin : g_trunc
         always_ff @(posedge clk) begin
            if (rst)
               q <= RST_V;
            else if (en) begin
               if (q >= LAST_V) q <= '0;
               else             q <= q + 1'b1;
            end
         end
      end
   endgenerate

   assert_range_R4: assert property (@(posedge clk) disable iff (rst) q <= LAST_V);
   assert_wrap_R3:  assert property (@(posedge clk) disable iff (rst)
                                     (en && q == LAST_V) |=> (q == '0));
   assert_hold_R2:  assert property (@(posedge clk) disable iff (rst)
                                     !en |=> $stable(q));
endmodule

// File: rtl/ct_sexa_stage.sv
module ct_sexa_stage
   import clk_time_pkg::*;
#(
   parameter int unsigned W = BCD_W
) (
   input  logic         clk,
   input  logic         rst,
   input  logic         en_in,
   output logic [W-1:0] units,
   output logic [W-1:0] tens,
   output logic         tc_out
);
   logic units_last, units_tc, tens_last, tens_tc;

   ct_digit #(.W(W), .LAST(UNITS_LAST), .RST_VAL(0)) u_units (
      .clk(clk), .rst(rst), .en(en_in),
      .q(units), .at_last(units_last), .tc(units_tc));

   ct_digit #(.W(W), .LAST(TENS_LAST), .RST_VAL(0)) u_tens (
      .clk(clk), .rst(rst), .en(units_tc),
      .q(tens), .at_last(tens_last), .tc(tens_tc));

   assign tc_out = tens_tc;

   assert_tc_R5: assert property (@(posedge clk) disable iff (rst)
                                  tc_out |-> (en_in && units == W'(9) && tens == W'(5)));
   assert_tens_step_R3: assert property (@(posedge clk) disable iff (rst)
                                  (en_in && units != W'(9)) |=> $stable(tens));
   assert_rollover_R4: assert property (@(posedge clk) disable iff (rst)
                                  tc_out |=> (units == '0 && tens == '0));
endmodule

// File: rtl/ct_hour_stage.sv
module ct_hour_stage
   import clk_time_pkg::*;
#(
   parameter int unsigned W = BCD_W
) (
   input  logic         clk,
   input  logic         rst,
   input  logic         en_in,
   output logic [W-1:0] units,
   output logic         tens,
   output logic         tc_out
);
   localparam logic [W-1:0] FIRST_U = W'(HOUR_FIRST % 10);
   localparam logic [W-1:0] LAST_U  = W'(HOUR_LAST % 10);
   localparam logic [W-1:0] NINE    = W'(UNITS_LAST);

   initial begin
      assert (W >= 4) else $error("ct_hour_stage: W below 4");
      assert (HOUR_LAST >= 10 && HOUR_LAST < 20) else $error("ct_hour_stage: bad HOUR_LAST");
   end

   logic at_last;
   assign at_last = tens && (units == LAST_U);
   assign tc_out  = en_in & at_last;

   always_ff @(posedge clk) begin
      if (rst) begin
         units <= LAST_U;
         tens  <= 1'b1;
      end else if (en_in) begin
         if (at_last) begin
            units <= FIRST_U;
            tens  <= 1'b0;
         end else if (units == NINE) begin
            units <= '0;
            tens  <= 1'b1;
         end else if (units > NINE) begin
            units <= '0;
         end else begin
            units <= units + 1'b1;
         end
      end
   end

   assert_hr_wrap_R7: assert property (@(posedge clk) disable iff (rst)
                                       (en_in && tens && units == W'(2)) |=> (units == W'(1) && !tens));
   assert_hr_ten_R6:  assert property (@(posedge clk) disable iff (rst)
                                       (en_in && units == W'(9)) |=> (units == '0 && tens));
   assert_hr_hold_R2: assert property (@(posedge clk) disable iff (rst)
                                       !en_in |=> ($stable(units) && $stable(tens)));
endmodule

// File: rtl/clock_time_chain.sv
module clock_time_chain
   import clk_time_pkg::*;
#(
   parameter int unsigned N_SEXA  = 2,
   parameter int unsigned DIGIT_W = BCD_W
) (
   input  logic                    clk,
   input  logic                    rst,
   input  logic                    cnt_en,
   output logic [N_SEXA*DIGIT_W-1:0] ms_units,
   output logic [N_SEXA*DIGIT_W-1:0] ms_tens,
   output logic [N_SEXA-1:0]       ms_tc,
   output logic [DIGIT_W-1:0]      hr_units,
   output logic                    hr_tens,
   output logic                    hr_tc
);
   initial begin
      assert (N_SEXA >= 1) else $error("clock_time_chain: N_SEXA must be at least 1");
      assert (DIGIT_W >= 4) else $error("clock_time_chain: DIGIT_W must be at least 4");
   end

   logic [N_SEXA:0] chain_en;
   assign chain_en[0] = cnt_en;

   generate
      for (genvar i = 0; i < N_SEXA; i++) begin : g_sexa
         ct_sexa_stage #(.W(DIGIT_W)) u_stage (
            .clk   (clk),
            .rst   (rst),
            .en_in (chain_en[i]),
            .units (ms_units[i*DIGIT_W +: DIGIT_W]),
            .tens  (ms_tens[i*DIGIT_W +: DIGIT_W]),
            .tc_out(ms_tc[i]));
         assign chain_en[i+1] = ms_tc[i];
      end
   endgenerate

   ct_hour_stage #(.W(DIGIT_W)) u_hours (
      .clk   (clk),
      .rst   (rst),
      .en_in (chain_en[N_SEXA]),
      .units (hr_units),
      .tens  (hr_tens),
      .tc_out(hr_tc));

   assert_reset_R1: assert property (@(posedge clk)
                                     rst |=> (ms_units == '0 && ms_tens == '0 &&
                                              hr_units == DIGIT_W'(2) && hr_tens));
   assert_hr_tc_R8: assert property (@(posedge clk) disable iff (rst)
                                     hr_tc |-> (ms_tc[N_SEXA-1] && hr_tens && hr_units == DIGIT_W'(2)));
   assert_cascade_R5: assert property (@(posedge clk) disable iff (rst)
                                     !cnt_en |-> (ms_tc == '0 && !hr_tc));
endmodule

// File: tb/clock_time_chain_tb.sv
module clock_time_chain_tb;
   localparam int N = 2;
   localparam int W = 4;

   logic clk = 1'b0;
   logic rst = 1'b1;
   logic cnt_en = 1'b0;
   logic [N*W-1:0] ms_units, ms_tens;
   logic [N-1:0]   ms_tc;
   logic [W-1:0]   hr_units;
   logic           hr_tens, hr_tc;

   always #10 clk = ~clk;

   clock_time_chain #(.N_SEXA(N), .DIGIT_W(W)) u_dut (
      .clk(clk), .rst(rst), .cnt_en(cnt_en),
      .ms_units(ms_units), .ms_tens(ms_tens), .ms_tc(ms_tc),
      .hr_units(hr_units), .hr_tens(hr_tens), .hr_tc(hr_tc));

   int n_chk = 0;
   int n_bad = 0;
   int m_sec = 0, m_min = 0, m_hr = 12;

   // segment table: mode 0 = hold, 1 = run, 2 = alternate enable
   localparam int NSEG = 8;
   localparam int SEG_MODE [0:NSEG-1] = '{1, 0, 2, 1, 0, 1, 0, 1};
   localparam int SEG_LEN  [0:NSEG-1] = '{65, 7, 40, 3600, 3, 40000, 2, 3200};

   task automatic chk(string tag, int act, int exp);
      n_chk++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
      end
   endtask

   task automatic chk_state(string tag);
      chk({tag, " sec units"}, int'(ms_units[3:0]), m_sec % 10);
      chk({tag, " sec tens"},  int'(ms_tens[3:0]),  m_sec / 10);
      chk({tag, " min units"}, int'(ms_units[7:4]), m_min % 10);
      chk({tag, " min tens"},  int'(ms_tens[7:4]),  m_min / 10);
      chk({tag, " hr units"},  int'(hr_units),      m_hr % 10);
      chk({tag, " hr tens"},   int'(hr_tens),       m_hr / 10);
   endtask

   task automatic chk_tc(string tag, logic en);
      logic t0, t1, th;
      t0 = en && (m_sec == 59);
      t1 = t0 && (m_min == 59);
      th = t1 && (m_hr == 12);
      chk({tag, " R5 ms_tc[0]"}, int'(ms_tc[0]), int'(t0));
      chk({tag, " R5 ms_tc[1]"}, int'(ms_tc[1]), int'(t1));
      chk({tag, " R8 hr_tc"},    int'(hr_tc),    int'(th));
   endtask

   task automatic model_step();
      m_sec++;
      if (m_sec == 60) begin
         m_sec = 0;
         m_min++;
         if (m_min == 60) begin
            m_min = 0;
            m_hr = (m_hr == 12) ? 1 : m_hr + 1;
         end
      end
   endtask

   // one clock: drive at negedge, check terminal counts, then state after edge
   task automatic cycle(logic en, string tag);
      @(negedge clk);
      cnt_en = en;
      #1;
      chk_tc(tag, en);
      @(posedge clk);
      #1;
      if (en) model_step();
      chk_state(tag);
   endtask

   task automatic do_reset(logic en);
      @(negedge clk);
      rst = 1'b1;
      cnt_en = en;
      @(posedge clk);
      #1;
      m_sec = 0; m_min = 0; m_hr = 12;
      @(negedge clk);
      rst = 1'b0;
      cnt_en = 1'b0;
   endtask

   initial begin
      do_reset(1'b0);
      chk_state("R1 reset");

      // table walk: R2 R3 R4 R5 R6 R7 R8 checked every cycle
      for (int s = 0; s < NSEG; s++) begin
         for (int c = 0; c < SEG_LEN[s]; c++) begin
            logic e;
            e = (SEG_MODE[s] == 1) || (SEG_MODE[s] == 2 && c[0]);
            cycle(e, "R3 R4 R6 R7 walk");
         end
      end

      // R9: reset wins over enable
      do_reset(1'b1);
      chk_state("R9 reset with enable");

      // advance to 12:59:59, then hold: no terminal count leaks (R8, R2)
      for (int c = 0; c < 3599; c++) cycle(1'b1, "R4 approach");
      chk_state("R8 at 12:59:59");
      cycle(1'b0, "R2 hold at 12:59:59");
      cycle(1'b0, "R2 hold again");
      @(negedge clk);
      cnt_en = 1'b1;
      #1;
      chk("R8 hr_tc enabled at 12:59:59", int'(hr_tc), 1);
      chk("R5 ms_tc all enabled", int'(ms_tc), 3);
      @(posedge clk);
      #1;
      model_step();
      chk_state("R7 12 to 01");
      chk("R7 hours value 01", int'(hr_tens) * 10 + int'(hr_units), 1);

      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin
      #(20 * 190000);
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end
endmodule